// File: doc/BRIEF.md
# Multi-Source Transceiver Reset Sequencer

This block produces the internal logic reset of a network transceiver from three causes: an active-low external reset pin, a self-clearing soft-reset bit set by a software write, and the return from power-down. Each cause has its own scope. The pin causes a full reset. It clears every register bit and enables the re-latching of the configuration straps. A soft reset clears only the register bits that are not marked as preserved, and it leaves the straps alone. A power-down exit clears no register and latches no strap. It only holds the logic in reset while the clocks settle.

Every sequence holds the core reset for a programmable number of clock cycles. By default the count is the stretch time in microseconds multiplied by the clock rate in MHz. The soft-reset bit reads back 1 while its own sequence runs. A one-cycle pulse marks the cycle in which the bit clears. The pin always wins. Any other cause that arrives while a sequence runs is dropped.

Top module: `phy_rst_seq`

## Requirements
- R1: A low level on `rst_pin_n` asserts `core_rst` and `strap_latch_en`, and drives `reg_clr` to all ones, at once, without waiting for a clock edge.
- R2: The pin release passes through a two-flop synchronizer and then a stretch of STRETCH_CYC cycles. Counted from a release just after a falling clock edge, `core_rst` is first seen low after STRETCH_CYC+2 rising edges.
- R3: `strap_latch_en` is high only during a pin-caused sequence. It stays high for that sequence's whole length, including the stretch, and `reg_clr` is all ones throughout.
- R4: A one-cycle `soft_rst_wr` pulse in an idle cycle holds `core_rst` for STRETCH_CYC cycles. `core_rst` is first seen low after STRETCH_CYC+1 rising edges, counting the edge that takes the write. During the sequence `soft_rst_bit` reads 1, `strap_latch_en` stays 0, and `reg_clr` equals the inverse of KEEP_MASK, so set KEEP_MASK bits are never cleared.
- R5: `soft_rst_done` is high for exactly one cycle. That cycle is the first one in which `soft_rst_bit` reads 0 after a soft sequence that finished normally.
- R6: A 1-to-0 change of `pwr_down` in an idle cycle holds `core_rst` for STRETCH_CYC cycles with the same timing as R4. During that sequence `reg_clr` is all zeros and `strap_latch_en`, `soft_rst_bit` and `soft_rst_done` stay 0.
- R7: While `pwr_down` is high and no sequence is running, `core_rst` stays 0.
- R8: A soft-reset write or a power-down exit that arrives while a sequence runs is ignored. The running sequence keeps its length and its outputs, and `soft_rst_bit` is unchanged.
- R9: A low pin during a soft or power-down sequence aborts it and restarts as a pin-caused sequence with the R2 and R3 behaviour. `soft_rst_done` does not pulse for the aborted soft sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| soft_rst_wr | input | 1 | One-cycle strobe: software wrote 1 to the soft-reset bit |
| pwr_down | input | 1 | Power-down level from the mode controller, synchronous |
| core_rst | output | 1 | Reset to the transceiver logic, active high |
| strap_latch_en | output | 1 | Enables re-latching of straps and configuration pins |
| reg_clr | output | REG_W | Per-bit clear to the register file, 1 = clear |
| soft_rst_bit | output | 1 | Read-back value of the self-clearing soft-reset bit |
| soft_rst_done | output | 1 | One-cycle pulse when the soft-reset bit clears |

## Verification
The hardest cases to reach are requests that arrive in the middle of a running sequence. These are a soft write or a power-down exit during a stretch, and a pin assertion that cuts a soft stretch short. The bench reaches them by counting cycles from the start of a sequence and injecting the second cause at a fixed count well before the stretch ends. It then measures the total length and watches `soft_rst_bit` and the `reg_clr` scope on every cycle, so a restarted or re-scoped sequence shows up as a wrong length or a wrong mask.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;

    // cause of the reset sequence currently running
    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_HARD  = 2'd1,
        SRC_SOFT  = 2'd2,
        SRC_PWRUP = 2'd3
    } src_e;

    // how far the register file is cleared
    typedef enum logic [1:0] {
        CLR_NONE   = 2'd0,
        CLR_ALL    = 2'd1,
        CLR_UNKEPT = 2'd2
    } clr_e;

    function automatic clr_e clr_scope(input src_e s);
        case (s)
            SRC_HARD: return CLR_ALL;
            SRC_SOFT: return CLR_UNKEPT;
            default:  return CLR_NONE;
        endcase
    endfunction

    function automatic logic relatch(input src_e s);
        return s == SRC_HARD;
    endfunction

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync (
    input  logic clk,
    input  logic pin_n,
    output logic hw_rst
);
    logic [1:0] stage;

    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) stage <= 2'b00;
        else        stage <= {stage[0], 1'b1};
    end

    assign hw_rst = ~stage[1];

    // R2: release needs two edges with the pin high
    a_r2_two_flop: assert property (@(posedge clk) disable iff (!pin_n)
        $fell(hw_rst) |-> $past(pin_n));
endmodule

// File: rtl/rst_stretch_cnt.sv
module rst_stretch_cnt #(
    parameter int STRETCH_CYC = 32000,
    localparam int CW = (STRETCH_CYC > 1) ? $clog2(STRETCH_CYC) : 1
) (
    input  logic clk,
    input  logic arst,
    input  logic run,
    output logic last
);
    logic [CW-1:0] cnt;

    assign last = run && (cnt == CW'(STRETCH_CYC - 1));

    always_ff @(posedge clk or posedge arst) begin
        if (arst)       cnt <= '0;
        else if (!run)  cnt <= '0;
        else if (last)  cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    // R2, R4: the count never passes the stretch length
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (arst)
        run && !last |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/rst_src_arb.sv
module rst_src_arb
    import phy_rst_pkg::*;
(
    input  logic clk,
    input  logic hw_rst,
    input  logic soft_wr,
    input  logic pwr_down,
    input  logic last,
    output src_e src,
    output logic done
);
    logic pd_q;
    logic pd_exit;

    always_ff @(posedge clk) pd_q <= pwr_down;

    assign pd_exit = pd_q && !pwr_down;

    always_ff @(posedge clk or posedge hw_rst) begin
        if (hw_rst) begin
            src  <= SRC_HARD;
            done <= 1'b0;
        end else begin
            done <= (src == SRC_SOFT) && last;
            if (src != SRC_IDLE) begin
                if (last) src <= SRC_IDLE;
            end else if (pd_exit) begin
                src <= SRC_PWRUP;
            end else if (soft_wr) begin
                src <= SRC_SOFT;
            end
        end
    end

    // R8: a running sequence keeps its cause until the stretch ends
    a_r8_no_restart: assert property (@(posedge clk) disable iff (hw_rst)
        (src != SRC_IDLE) && !last |=> src == $past(src));
    // R5: the done pulse lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (hw_rst)
        done |=> !done);
endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq
    import phy_rst_pkg::*;
#(
    parameter int          CLK_MHZ    = 125,
    parameter int          STRETCH_US = 256,
    parameter int          REG_W      = 16,
    parameter logic [15:0] KEEP_MASK  = 16'hF00F,
    localparam int         STRETCH_CYC = CLK_MHZ * STRETCH_US
) (
    input  logic             clk,
    input  logic             rst_pin_n,
    input  logic             soft_rst_wr,
    input  logic             pwr_down,
    output logic             core_rst,
    output logic             strap_latch_en,
    output logic [REG_W-1:0] reg_clr,
    output logic             soft_rst_bit,
    output logic             soft_rst_done
);
    localparam logic [REG_W-1:0] KEEP = REG_W'(KEEP_MASK);

    logic hw_rst;
    logic last;
    src_e src;

    rst_pin_sync u_sync (
        .clk    (clk),
        .pin_n  (rst_pin_n),
        .hw_rst (hw_rst)
    );

    rst_stretch_cnt #(.STRETCH_CYC(STRETCH_CYC)) u_cnt (
        .clk  (clk),
        .arst (hw_rst),
        .run  (src != SRC_IDLE),
        .last (last)
    );

    rst_src_arb u_arb (
        .clk      (clk),
        .hw_rst   (hw_rst),
        .soft_wr  (soft_rst_wr),
        .pwr_down (pwr_down),
        .last     (last),
        .src      (src),
        .done     (soft_rst_done)
    );

    always_comb begin
        case (clr_scope(src))
            CLR_ALL:    reg_clr = '1;
            CLR_UNKEPT: reg_clr = ~KEEP;
            default:    reg_clr = '0;
        endcase
    end

    assign core_rst       = hw_rst || (src != SRC_IDLE);
    assign strap_latch_en = relatch(src);
    assign soft_rst_bit   = (src == SRC_SOFT);

    // R4: a soft sequence spares the kept bits and holds core reset
    a_r4_soft_scope: assert property (@(posedge clk) disable iff (hw_rst)
        soft_rst_bit |-> core_rst && !strap_latch_en && ((reg_clr & KEEP) == '0));
    // R6: a non-soft, non-pin reset clears nothing
    a_r6_pd_no_clear: assert property (@(posedge clk) disable iff (hw_rst)
        core_rst && !soft_rst_bit && !strap_latch_en |-> reg_clr == '0);
    // R5: the soft bit clearing is always reported
    a_r5_done_on_clear: assert property (@(posedge clk) disable iff (hw_rst)
        $fell(soft_rst_bit) |-> soft_rst_done);
    // R3: strap latching only with a full clear under reset
    a_r3_strap_full: assert property (@(posedge clk) disable iff (1'b0)
        strap_latch_en |-> core_rst && (reg_clr == '1));
endmodule

// File: tb/phy_rst_seq_test.sv
`timescale 1ns/1ps
module phy_rst_seq_test;
    localparam int STR = 8;
    localparam logic [15:0] KEEP = 16'hF00F;

    typedef struct packed {
        logic       use_pd;
        logic [1:0] intf;   // 0 none, 1 soft write, 2 power-down exit
        logic [7:0] len;
    } vec_t;

    localparam vec_t VEC [0:3] = '{
        '{1'b0, 2'd0, 8'(STR + 1)},
        '{1'b1, 2'd0, 8'(STR + 1)},
        '{1'b0, 2'd2, 8'(STR + 1)},
        '{1'b1, 2'd1, 8'(STR + 1)}
    };

    logic clk = 1'b0;
    logic rst_pin_n = 1'b1;
    logic soft_rst_wr = 1'b0;
    logic pwr_down = 1'b0;
    logic core_rst, strap_latch_en, soft_rst_bit, soft_rst_done;
    logic [15:0] reg_clr;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    phy_rst_seq #(.CLK_MHZ(1), .STRETCH_US(STR), .REG_W(16), .KEEP_MASK(KEEP)) uut (
        .clk(clk), .rst_pin_n(rst_pin_n), .soft_rst_wr(soft_rst_wr),
        .pwr_down(pwr_down), .core_rst(core_rst), .strap_latch_en(strap_latch_en),
        .reg_clr(reg_clr), .soft_rst_bit(soft_rst_bit), .soft_rst_done(soft_rst_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // pin pulse starting at a falling edge, measured from release
    task automatic hw_seq(input string tag);
        int n = 0;
        bit bad = 0;
        @(negedge clk);
        rst_pin_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_pin_n = 1'b1;
        while (n < 100) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (!core_rst) break;
            if (!strap_latch_en || reg_clr !== 16'hFFFF) bad = 1;
        end
        chk({tag, " R2 length"}, n, STR + 2);
        chk({tag, " R3 strap/clear held"}, bad, 0);
        chk({tag, " R3 strap drops"}, strap_latch_en, 0);
    endtask

    task automatic run_seq(input vec_t v, input string tag);
        int n = 0;
        bit bad = 0;
        bit bad7 = 0;
        logic [15:0] em;
        em = v.use_pd ? 16'h0000 : ~KEEP;
        if (v.use_pd) begin
            @(negedge clk);
            pwr_down = 1'b1;
            repeat (3) begin
                @(negedge clk);
                if (core_rst) bad7 = 1;
            end
            chk({tag, " R7 no reset in power-down"}, bad7, 0);
        end
        @(negedge clk);
        if (v.use_pd) pwr_down = 1'b0;
        else soft_rst_wr = 1'b1;
        while (n < 100) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            soft_rst_wr = 1'b0;
            if (!core_rst) break;
            if (reg_clr !== em || soft_rst_bit !== !v.use_pd || strap_latch_en) bad = 1;
            if (n == 2 && v.intf == 2'd1) soft_rst_wr = 1'b1;
            if (n == 2 && v.intf == 2'd2) pwr_down = 1'b1;
            if (n == 3 && v.intf == 2'd2) pwr_down = 1'b0;
        end
        chk({tag, v.use_pd ? " R6 length" : " R4 length"}, n, 32'(v.len));
        chk({tag, v.use_pd ? " R6 scope" : " R4 scope"}, bad, 0);
        chk({tag, " R5 done pulse"}, soft_rst_done, !v.use_pd);
        chk({tag, " R5 bit cleared"}, soft_rst_bit, 0);
        @(negedge clk);
        chk({tag, " R5 done one cycle"}, soft_rst_done, 0);
        chk({tag, " R8 no restart"}, core_rst, 0);
    endtask

    initial begin
        #1 rst_pin_n = 1'b0;
        #1;
        chk("R1 async assert core_rst", core_rst, 1);
        chk("R1 async strap", strap_latch_en, 1);
        chk("R1 async clear all", reg_clr, 16'hFFFF);
        chk("R1 soft bit low", soft_rst_bit, 0);
        @(negedge clk);
        rst_pin_n = 1'b1;
        begin
            int n = 0;
            while (n < 100) begin
                @(posedge clk);
                n++;
                @(negedge clk);
                if (!core_rst) break;
            end
            chk("R2 power-up release length", n, STR + 2);
        end
        chk("R3 strap low when idle", strap_latch_en, 0);

        for (int i = 0; i < 4; i++) begin
            run_seq(VEC[i], $sformatf("vec%0d", i));
            repeat (2) @(negedge clk);
        end

        // R1: mid-cycle pin assertion seen before any clock edge
        @(negedge clk);
        #0.5 rst_pin_n = 1'b0;
        #0.5;
        chk("R1 mid-cycle assert", core_rst, 1);
        @(negedge clk);
        rst_pin_n = 1'b1;
        repeat (STR + 4) @(negedge clk);
        chk("R2 idle after pin", core_rst, 0);

        // R9: pin during a soft sequence
        soft_rst_wr = 1'b1;
        @(negedge clk);
        soft_rst_wr = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 soft running", soft_rst_bit, 1);
        hw_seq("R9 soft abort");
        chk("R9 no done after abort", soft_rst_done, 0);

        // R9: pin during a power-down exit sequence
        pwr_down = 1'b1;
        repeat (2) @(negedge clk);
        pwr_down = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 pd running", core_rst, 1);
        hw_seq("R9 pd abort");
        chk("R9 soft bit low", soft_rst_bit, 0);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule